// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the synchronous front end of a byte-wide flash command port. Each bus write reaches it as a one-cycle strobe with an 18-bit address and an 8-bit data byte. The block follows the multi-write unlock protocol and works out which operation the host wants. A recognised byte program, chip erase or sector erase leaves the block as a one-cycle request to the execution engine, together with the latched address and data. A boot-sector lock command, an identification mode and two forms of reset are handled inside the block.

The execution engine drives a busy input back into the block. While busy is high, the reported mode is busy and every write is dropped. A synchronous low-voltage-inhibit input clears any partly entered sequence and blocks all writes while it is high. The boot-lock flag stays set until the asynchronous reset.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After rst_ni is released, mode_o is 0 (read array), op_valid_o is 0, boot_lock_o is 0 and id_data_o is 00h.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a fourth write (PA, PD), produce op_valid_o high for exactly one cycle after the fourth write, with op_kind_o = 1, op_addr_o = PA and op_data_o = PD. In that fourth write a data value of F0h is program data and not a reset.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h produce a one-cycle request with op_kind_o = 2.
- R4: If the sixth write of the erase sequence carries 30h, at any address, it produces a one-cycle request with op_kind_o = 3 and op_addr_o equal to that write's address.
- R5: If the sixth write of the erase sequence is 40h@5555h, boot_lock_o rises in the next cycle and no request is issued. After that, only rst_ni clears boot_lock_o.
- R6: While boot_lock_o is 1, program and sector-erase requests whose address is at or above 3C000h are dropped, and chip erase is dropped. Requests below 3C000h still go out.
- R7: Bits 17 and 16 of the address are ignored when a write is compared against 5555h or 2AAAh.
- R8: A write with the wrong address or data at any step abandons the sequence and leaves the block in read-array mode. The next sequence must start again with AAh@5555h.
- R9: A single write of F0h to any address outside the program-data step returns the block to read array (mode_o = 0). AAh@5555h, 55h@2AAAh, F0h@5555h has the same effect.
- R10: After AAh@5555h, 55h@2AAAh, 90h@5555h, mode_o is 1, and id_data_o depends only on addr_i[7:0], for any number of reads: 00h, 04h, 08h and 0Ch give MFR_ID; 01h gives DEV_ID; 02h gives 00h with the boot-lock state on bit 0; any other address gives 00h. Outside mode 1, id_data_o is 00h.
- R11: While busy_i is 1, mode_o is 2, id_data_o is 00h and writes are ignored. A sequence that was partly entered before busy continues afterwards from where it stopped.
- R12: While lvi_i is 1, writes are ignored. One cycle of lvi_i clears a partly entered sequence and the identification mode, but does not clear boot_lock_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvi_i | input | 1 | Low-voltage inhibit, synchronous |
| busy_i | input | 1 | Execution engine is running an operation |
| wr_i | input | 1 | One-cycle bus write strobe |
| addr_i | input | 18 | Write address; also the identification read address |
| wdata_i | input | 8 | Write data |
| op_valid_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| op_addr_o | output | 18 | Address latched with the request |
| op_data_o | output | 8 | Data latched with the request |
| mode_o | output | 2 | 0 read array, 1 identification, 2 busy |
| boot_lock_o | output | 1 | Boot sector is locked |
| id_data_o | output | 8 | Identification code for addr_i |

## Verification
Two situations are hard to reach from the ports. The first is a write dropped in the middle of a sequence: a busy or inhibit cycle has to arrive between two unlock writes, and the only sign that the write was dropped or that the sequence was cleared is whether a later completing write still issues a request. The second is the locked-sector rejection, which needs the full six-write lock sequence first and then targets on both sides of 3C000h. The stimulus builds both cases explicitly. A behavioural reference model, driven by the same inputs, is compared with every output on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int KEY_W  = 16;

  localparam logic [DATA_W-1:0] CMD_UNLK_A = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_UNLK_B = 8'h55;
  localparam logic [DATA_W-1:0] CMD_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_ESETUP = 8'h80;
  localparam logic [DATA_W-1:0] CMD_IDENT  = 8'h90;
  localparam logic [DATA_W-1:0] CMD_RESET  = 8'hF0;
  localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] CMD_SECT   = 8'h30;
  localparam logic [DATA_W-1:0] CMD_LOCK   = 8'h40;

  typedef enum logic [1:0] {MODE_READ = 2'd0, MODE_IDENT = 2'd1, MODE_BUSY = 2'd2} mode_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PROG = 2'd1, OP_CHIP = 2'd2, OP_SECT = 2'd3} op_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_U2, ST_CMD, ST_PDATA, ST_E1, ST_E2, ST_ECMD
  } step_e;
endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import flash_cmd_pkg::*;
#(
  parameter int              AW        = 18,
  parameter logic [KEY_W-1:0] KEY_A    = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_B    = 16'h2AAA,
  parameter logic [AW-1:0]   BOOT_BASE = 18'h3C000
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              unl_a_o,
  output logic              unl_b_o,
  output logic              at_key_o,
  output logic              rst_code_o,
  output logic              in_boot_o
);
  // upper address bits do not take part in key matching
  logic key_a_hit, key_b_hit;
  assign key_a_hit  = addr_i[KEY_W-1:0] == KEY_A;
  assign key_b_hit  = addr_i[KEY_W-1:0] == KEY_B;
  assign at_key_o   = key_a_hit;
  assign unl_a_o    = key_a_hit && data_i == CMD_UNLK_A;
  assign unl_b_o    = key_b_hit && data_i == CMD_UNLK_B;
  assign rst_code_o = data_i == CMD_RESET;
  assign in_boot_o  = addr_i >= BOOT_BASE;
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int            AW        = 18,
  parameter logic [AW-1:0] BOOT_BASE = 18'h3C000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvi_i,
  input  logic              busy_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              unl_a_i,
  input  logic              unl_b_i,
  input  logic              at_key_i,
  input  logic              rst_code_i,
  input  logic              in_boot_i,
  output logic              op_valid_o,
  output op_e               op_kind_o,
  output logic [AW-1:0]     op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              ident_o,
  output logic              lock_o
);
  step_e step_q, step_d;
  logic  ident_q, ident_d, lock_q, lock_d, fire;
  op_e   kind_d;

  always_comb begin
    step_d  = step_q;
    ident_d = ident_q;
    lock_d  = lock_q;
    fire    = 1'b0;
    kind_d  = OP_NONE;
    if (lvi_i) begin
      step_d  = ST_IDLE;
      ident_d = 1'b0;
    end else if (wr_i && !busy_i) begin
      step_d  = ST_IDLE;
      ident_d = 1'b0;
      // F0h aborts everywhere except as program payload
      if (!(rst_code_i && step_q != ST_PDATA)) begin
        case (step_q)
          ST_IDLE: if (unl_a_i) begin step_d = ST_U2;  ident_d = ident_q; end
          ST_U2:   if (unl_b_i) begin step_d = ST_CMD; ident_d = ident_q; end
          ST_CMD: if (at_key_i) begin
            if (data_i == CMD_PROG)        step_d  = ST_PDATA;
            else if (data_i == CMD_ESETUP) step_d  = ST_E1;
            else if (data_i == CMD_IDENT)  ident_d = 1'b1;
          end
          ST_PDATA: begin
            fire   = !(lock_q && in_boot_i);
            kind_d = OP_PROG;
          end
          ST_E1: if (unl_a_i) step_d = ST_E2;
          ST_E2: if (unl_b_i) step_d = ST_ECMD;
          ST_ECMD: begin
            if (data_i == CMD_SECT) begin
              fire   = !(lock_q && in_boot_i);
              kind_d = OP_SECT;
            end else if (at_key_i && data_i == CMD_CHIP) begin
              fire   = !lock_q;
              kind_d = OP_CHIP;
            end else if (at_key_i && data_i == CMD_LOCK) begin
              lock_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q     <= ST_IDLE;
      ident_q    <= 1'b0;
      lock_q     <= 1'b0;
      op_valid_o <= 1'b0;
      op_kind_o  <= OP_NONE;
      op_addr_o  <= '0;
      op_data_o  <= '0;
    end else begin
      step_q     <= step_d;
      ident_q    <= ident_d;
      lock_q     <= lock_d;
      op_valid_o <= fire;
      if (fire) begin
        op_kind_o <= kind_d;
        op_addr_o <= addr_i;
        op_data_o <= data_i;
      end
    end
  end

  assign ident_o = ident_q;
  assign lock_o  = lock_q;

  p_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);
  p_prog_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == OP_PROG) |-> $past(step_q) == ST_PDATA);
  p_lock_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  p_boot_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && $past(lock_q)) |-> (op_kind_o != OP_CHIP && op_addr_o < BOOT_BASE));
  p_busy_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !lvi_i) |=> ($stable(step_q) && !op_valid_o));
  p_lvi_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvi_i |=> (step_q == ST_IDLE && !ident_q && !op_valid_o));
endmodule

// File: rtl/fcd_ident.sv
module fcd_ident
  import flash_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_ID     = 8'h7F,
  parameter logic [DATA_W-1:0] DEV_ID     = 8'hA5,
  parameter int                MFR_SLOTS  = 4,
  parameter int                MFR_STRIDE = 4,
  parameter logic [7:0]        DEV_ADDR   = 8'h01,
  parameter logic [7:0]        LOCK_ADDR  = 8'h02
) (
  input  logic [7:0]        sel_i,
  input  logic              ident_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] code_o
);
  logic [MFR_SLOTS-1:0] mfr_hit;
  for (genvar g = 0; g < MFR_SLOTS; g++) begin : g_mfr
    assign mfr_hit[g] = sel_i == 8'(g * MFR_STRIDE);
  end

  always_comb begin
    code_o = '0;
    if (ident_i) begin
      if (|mfr_hit)               code_o = MFR_ID;
      else if (sel_i == DEV_ADDR)  code_o = DEV_ID;
      else if (sel_i == LOCK_ADDR) code_o = {{(DATA_W-1){1'b0}}, lock_i};
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int            AW        = 18,
  parameter logic [AW-1:0] BOOT_BASE = 18'h3C000,
  parameter logic [7:0]    MFR_ID    = 8'h7F,
  parameter logic [7:0]    DEV_ID    = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvi_i,
  input  logic          busy_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          op_valid_o,
  output logic [1:0]    op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic [1:0]    mode_o,
  output logic          boot_lock_o,
  output logic [7:0]    id_data_o
);
  logic unl_a, unl_b, at_key, rst_code, in_boot, ident, lock;
  op_e  kind;

  fcd_match #(.AW(AW), .BOOT_BASE(BOOT_BASE)) u_match (
    .addr_i(addr_i), .data_i(wdata_i), .unl_a_o(unl_a), .unl_b_o(unl_b),
    .at_key_o(at_key), .rst_code_o(rst_code), .in_boot_o(in_boot)
  );

  fcd_seq #(.AW(AW), .BOOT_BASE(BOOT_BASE)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvi_i(lvi_i), .busy_i(busy_i), .wr_i(wr_i),
    .addr_i(addr_i), .data_i(wdata_i), .unl_a_i(unl_a), .unl_b_i(unl_b),
    .at_key_i(at_key), .rst_code_i(rst_code), .in_boot_i(in_boot),
    .op_valid_o(op_valid_o), .op_kind_o(kind), .op_addr_o(op_addr_o),
    .op_data_o(op_data_o), .ident_o(ident), .lock_o(lock)
  );

  fcd_ident #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_ident (
    .sel_i(addr_i[7:0]), .ident_i(ident && !busy_i), .lock_i(lock), .code_o(id_data_o)
  );

  assign op_kind_o   = kind;
  assign boot_lock_o = lock;
  assign mode_o      = busy_i ? MODE_BUSY : (ident ? MODE_IDENT : MODE_READ);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvi = 1'b0, busy = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        op_valid, boot_lock;
  logic [1:0]  op_kind, mode;
  logic [17:0] op_addr;
  logic [7:0]  op_data, id_data;

  localparam logic [7:0] MFR = 8'h7F;
  localparam logic [7:0] DEV = 8'hA5;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.MFR_ID(MFR), .DEV_ID(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lvi_i(lvi), .busy_i(busy), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .op_valid_o(op_valid), .op_kind_o(op_kind),
    .op_addr_o(op_addr), .op_data_o(op_data), .mode_o(mode),
    .boot_lock_o(boot_lock), .id_data_o(id_data)
  );

  int    tests = 0, fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_step;   // 0 idle,1 AA seen,2 55 seen,3 program data,4 80 seen,5 AA,6 55
  bit          m_ident, m_lock, e_valid;
  int          e_kind;
  logic [17:0] e_addr;
  logic [7:0]  e_data;

  function automatic logic [7:0] code_of(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C) return MFR;
    if (a == 8'h01) return DEV;
    if (a == 8'h02) return {7'b0, m_lock};
    return 8'h00;
  endfunction

  task automatic issue(input int k, input logic [17:0] a, input logic [7:0] d);
    e_valid = 1'b1; e_kind = k; e_addr = a; e_data = d;
  endtask

  task automatic model_write(input logic [17:0] a, input logic [7:0] d);
    bit k5, k2, boot;
    k5 = a[15:0] == 16'h5555;
    k2 = a[15:0] == 16'h2AAA;
    boot = a >= 18'h3C000;
    if (d == 8'hF0 && m_step != 3) begin m_step = 0; m_ident = 0; return; end
    if (m_step == 0) begin
      if (k5 && d == 8'hAA) m_step = 1; else m_ident = 0;
    end else if (m_step == 1) begin
      if (k2 && d == 8'h55) m_step = 2; else begin m_step = 0; m_ident = 0; end
    end else if (m_step == 2) begin
      m_step = 0; m_ident = 0;
      if (k5 && d == 8'hA0) m_step = 3;
      else if (k5 && d == 8'h80) m_step = 4;
      else if (k5 && d == 8'h90) m_ident = 1;
    end else if (m_step == 3) begin
      m_step = 0; m_ident = 0;
      if (!(m_lock && boot)) issue(1, a, d);
    end else if (m_step == 4 || m_step == 5) begin
      if ((m_step == 4 && k5 && d == 8'hAA) || (m_step == 5 && k2 && d == 8'h55))
        m_step = m_step + 1;
      else begin m_step = 0; m_ident = 0; end
    end else begin
      m_step = 0; m_ident = 0;
      if (d == 8'h30) begin if (!(m_lock && boot)) issue(3, a, d); end
      else if (k5 && d == 8'h10) begin if (!m_lock) issue(2, a, d); end
      else if (k5 && d == 8'h40) m_lock = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_ident = 0; m_lock = 0; e_valid = 0;
    end else begin
      e_valid = 0;
      if (lvi) begin m_step = 0; m_ident = 0; end
      else if (wr && !busy) model_write(addr, wdata);
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(cur_req, "mode", mode, busy ? 2 : (m_ident ? 1 : 0));
      chk(cur_req, "id_data", id_data, (m_ident && !busy) ? code_of(addr[7:0]) : 8'h00);
      chk(cur_req, "boot_lock", boot_lock, m_lock);
      chk(cur_req, "op_valid", op_valid, e_valid);
      if (e_valid) begin
        chk(cur_req, "op_kind", op_kind, e_kind);
        chk(cur_req, "op_addr", op_addr, e_addr);
        chk(cur_req, "op_data", op_data, e_data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wrt(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic unlock();
    wrt(18'h05555, 8'hAA); wrt(18'h02AAA, 8'h55);
  endtask
  task automatic prog(input logic [17:0] a, input logic [7:0] d);
    unlock(); wrt(18'h05555, 8'hA0); wrt(a, d);
  endtask
  task automatic erase(input logic [17:0] a, input logic [7:0] d);
    unlock(); wrt(18'h05555, 8'h80); unlock(); wrt(a, d);
  endtask
  task automatic rd(input logic [17:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    chk(req, "id_data", id_data, exp);
  endtask
  task automatic chk_op(input string req, input int k, input logic [17:0] a, input logic [7:0] d);
    chk(req, "op_valid", op_valid, 1);
    chk(req, "op_kind", op_kind, k);
    chk(req, "op_addr", op_addr, a);
    chk(req, "op_data", op_data, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "mode", mode, 0); chk("R1", "op_valid", op_valid, 0);
    chk("R1", "boot_lock", boot_lock, 0); chk("R1", "id_data", id_data, 0);

    cur_req = "R2";
    prog(18'h12345, 8'h5A); chk_op("R2", 1, 18'h12345, 8'h5A);
    @(negedge clk); chk("R2", "op_valid pulse", op_valid, 0);
    prog(18'h00777, 8'hF0); chk_op("R2", 1, 18'h00777, 8'hF0);

    cur_req = "R7";
    wrt(18'h35555, 8'hAA); wrt(18'h12AAA, 8'h55); wrt(18'h25555, 8'hA0); wrt(18'h00010, 8'h77);
    chk_op("R7", 1, 18'h00010, 8'h77);

    cur_req = "R3";
    erase(18'h05555, 8'h10); chk_op("R3", 2, 18'h05555, 8'h10);
    cur_req = "R4";
    erase(18'h21000, 8'h30); chk_op("R4", 3, 18'h21000, 8'h30);

    cur_req = "R8";
    unlock(); wrt(18'h05555, 8'h12); wrt(18'h05555, 8'hA0); wrt(18'h00100, 8'h33);
    chk("R8", "op_valid after bad cmd", op_valid, 0);
    wrt(18'h05555, 8'hAA); wrt(18'h02AAB, 8'h55); wrt(18'h05555, 8'hA0); wrt(18'h00000, 8'h5A);
    chk("R8", "op_valid after bad addr", op_valid, 0);
    unlock(); wrt(18'h05555, 8'h80); wrt(18'h05555, 8'hAA); wrt(18'h05555, 8'h55); wrt(18'h05555, 8'h10);
    chk("R8", "op_valid after bad erase unlock", op_valid, 0);
    chk("R8", "mode", mode, 0);

    cur_req = "R10";
    unlock(); wrt(18'h05555, 8'h90);
    chk("R10", "mode ident", mode, 1);
    rd(18'h00000, MFR, "R10"); rd(18'h00001, DEV, "R10");
    rd(18'h00004, MFR, "R10"); rd(18'h00008, MFR, "R10"); rd(18'h0000C, MFR, "R10");
    rd(18'h00002, 8'h00, "R10"); rd(18'h00033, 8'h00, "R10");
    rd(18'h3FF01, DEV, "R10"); rd(18'h00000, MFR, "R10");

    cur_req = "R9";
    wrt(18'h12345, 8'hF0); chk("R9", "mode after F0", mode, 0);
    rd(18'h00000, 8'h00, "R10");
    unlock(); wrt(18'h05555, 8'h90); chk("R9", "mode ident", mode, 1);
    unlock(); wrt(18'h05555, 8'hF0); chk("R9", "mode after 3-write reset", mode, 0);
    unlock(); wrt(18'h05555, 8'h80); wrt(18'h00000, 8'hF0); wrt(18'h05555, 8'hAA);
    wrt(18'h02AAA, 8'h55); wrt(18'h05555, 8'h10);
    chk("R9", "F0 mid-sequence aborts", op_valid, 0);

    cur_req = "R11";
    unlock();
    @(negedge clk); busy = 1'b1; #1; chk("R11", "mode busy", mode, 2);
    wrt(18'h05555, 8'h12);
    @(negedge clk); busy = 1'b0;
    wrt(18'h05555, 8'hA0); wrt(18'h00300, 8'h66);
    chk_op("R11", 1, 18'h00300, 8'h66);
    @(negedge clk); busy = 1'b1;
    prog(18'h00400, 8'h44); chk("R11", "op_valid while busy", op_valid, 0);
    @(negedge clk); busy = 1'b0;
    unlock(); wrt(18'h05555, 8'h90);
    @(negedge clk); busy = 1'b1; addr = 18'h00001; #1;
    chk("R11", "id_data busy", id_data, 0); chk("R11", "mode busy", mode, 2);
    @(negedge clk); busy = 1'b0; #1; chk("R11", "mode back ident", mode, 1);
    wrt(18'h00000, 8'hF0);

    cur_req = "R12";
    unlock();
    @(negedge clk); lvi = 1'b1;
    wrt(18'h05555, 8'hA0);
    @(negedge clk); lvi = 1'b0;
    wrt(18'h00300, 8'h66); chk("R12", "op_valid after lvi", op_valid, 0);
    unlock(); wrt(18'h05555, 8'h90);
    @(negedge clk); lvi = 1'b1;
    @(negedge clk); lvi = 1'b0; chk("R12", "mode after lvi", mode, 0);

    cur_req = "R5";
    erase(18'h05555, 8'h40);
    chk("R5", "boot_lock set", boot_lock, 1); chk("R5", "no request", op_valid, 0);

    cur_req = "R6";
    prog(18'h3C000, 8'h11); chk("R6", "prog boot base", op_valid, 0);
    prog(18'h3BFFF, 8'h22); chk_op("R6", 1, 18'h3BFFF, 8'h22);
    prog(18'h3FFFF, 8'h33); chk("R6", "prog boot top", op_valid, 0);
    erase(18'h3D000, 8'h30); chk("R6", "sector erase boot", op_valid, 0);
    erase(18'h20000, 8'h30); chk_op("R6", 3, 18'h20000, 8'h30);
    erase(18'h05555, 8'h10); chk("R6", "chip erase locked", op_valid, 0);

    cur_req = "R10";
    unlock(); wrt(18'h05555, 8'h90);
    rd(18'h00002, 8'h01, "R10");
    wrt(18'h00000, 8'hF0);

    cur_req = "R12";
    @(negedge clk); lvi = 1'b1;
    @(negedge clk); lvi = 1'b0; chk("R12", "lock kept over lvi", boot_lock, 1);

    cur_req = "R5";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R5", "lock cleared by reset", boot_lock, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule